// File: doc/BRIEF.md
# Flash Program/Erase Unlock Sequencer

This block stands between a host register interface and a paged non-volatile memory array. It keeps program and erase operations locked until the host has gone through a fixed ritual. First the host selects a page. Then it writes two key bytes to the control register. Then it writes the same page number again to confirm. The confirming write is refused if the page sits in a protected sector or if the write-protect strap is low. Once unlocked, the host may start one page erase or one mass erase, or any number of byte programs. A write that does not fit the current step relocks the controller.

A single shared select register carries two meanings. It normally holds the page number. After the protect-select command, the next write to it is taken as a sector protect mask instead, and protect bits can only be set. A 16-bit timing register gives the length of every array operation in clock cycles. While an operation runs, the block raises a busy strobe toward the array and reports a busy status. It ignores host writes until the operation has finished.

In one cycle only one host write counts. A control write takes precedence over a select write, and a select write takes precedence over a program strobe. Page number bits: the low 7 bits of the select byte. Sector: page bits [6:4], so there are eight sectors of sixteen pages each.

Top module: `flash_unlock_seq`

## Requirements
- R1: After reset the status is 000000 (locked), the protect mask and page register are zero, and the array strobe is low with operation code 00.
- R2: From locked, a control write of 73H gives status 000001. A following control write of 8CH gives status 000010. Any other control value at either step, and any select write or program strobe at the first-key step, returns the status to 000000.
- R3: In the second-key state, a select write whose low 7 bits equal the page held before the keys gives status 000011 (unlocked). A different page gives 000000. In both cases the written page becomes the page register value.
- R4: The confirming select write leaves the block locked when the protect bit of the page's sector (page bits [6:4]) is set.
- R5: A control write of 5EH from locked (or from the protect-select state) gives status 000100. The next select write ORs its byte into the protect mask, leaves the page register unchanged and returns to locked. A select write in any other state updates the page register and never the mask.
- R6: When unlocked, control 95H starts a page erase (operation code 10). Control 63H starts a mass erase (code 11) only if the protect mask is zero. A program strobe starts a byte program (code 01) that carries the page, the 6-bit offset and the data. Any other control value, a select write, or a refused command relocks.
- R7: An operation keeps status 000101 and the array strobe high for exactly as many cycles as the timing register holds. With the timing register at zero, an erase or program command is refused and the block relocks.
- R8: With the write-protect strap low, the confirming select write relocks, and erase or program commands in the unlocked state relock.
- R9: During an operation the status, operation code, page, offset and data stay fixed. Control writes, select writes and program strobes have no effect. When a byte program ends the block returns to unlocked; when an erase ends it returns to locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_din | input | 8 | Control register write data (keys and commands) |
| sel_we | input | 1 | Shared page/protect register write strobe |
| sel_din | input | 8 | Shared register write data |
| freq_we | input | 1 | Timing register write strobe |
| freq_din | input | 16 | Operation length in clock cycles |
| prog_we | input | 1 | Byte program strobe |
| prog_offset | input | 6 | Byte offset within the page |
| prog_data | input | 8 | Byte to program |
| wp_n | input | 1 | Write-protect strap, low disables program and erase |
| status | output | 6 | Sequencer state code |
| prot_mask | output | 8 | Sector protect mask |
| page_sel | output | 7 | Page register value |
| arr_busy | output | 1 | Array operation strobe |
| arr_op | output | 2 | Array operation code (01 program, 10 page erase, 11 mass erase) |
| arr_page | output | 7 | Page of the running operation |
| arr_offset | output | 6 | Offset of the running byte program |
| arr_data | output | 8 | Data of the running byte program |

## Verification
The bench goes after the edges of the key ritual. It sends a wrong second key, which a lax sequencer would accept and so reach the confirm step. It confirms with a different page, which would unlock the wrong page if the compare were missing. It confirms inside a protected sector, which a missing sector lookup would unlock. It attempts a mass erase while a protect bit is set, which would wipe protected data if the block allowed it. It also sets the timing register to zero and to one, where an off-by-one timer stretches or hangs the busy phase. It throws writes into a running operation, which would change the operation code or escape busy if they were not ignored. It drops the write-protect strap between unlock and command, which a design that checks the strap only at unlock would ignore.

// File: rtl/fsu_pkg.sv
// Shared types and command codes for the flash unlock sequencer.
// Assumes: state codes double as the visible 6-bit status value.
package fsu_pkg;

    typedef enum logic [5:0] {
        ST_LOCKED = 6'b000000,
        ST_KEY1   = 6'b000001,
        ST_KEY2   = 6'b000010,
        ST_OPEN   = 6'b000011,
        ST_PSEL   = 6'b000100,
        ST_BUSY   = 6'b000101
    } fsu_state_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_PROG   = 2'b01,
        OP_PERASE = 2'b10,
        OP_MERASE = 2'b11
    } fsu_op_e;

    localparam logic [7:0] KEY_FIRST      = 8'h73;
    localparam logic [7:0] KEY_SECOND     = 8'h8C;
    localparam logic [7:0] CMD_PAGE_ERASE = 8'h95;
    localparam logic [7:0] CMD_MASS_ERASE = 8'h63;
    localparam logic [7:0] CMD_PROT_SEL   = 8'h5E;

endpackage

// File: rtl/fsu_regs.sv
// Page, sector-protect and timing registers of the unlock sequencer.
// Does: holds the page number, a set-only protect mask and the operation length,
//       and looks up whether the page on the select bus lies in a protected sector.
// Assumes: the controller raises at most one of page_we / prot_we per cycle.
module fsu_regs #(
    parameter int PAGE_W = 7,
    parameter int SECT_W = 3,
    parameter int FREQ_W = 16,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_din,
    input  logic              prot_we,
    input  logic [NSECT-1:0]  prot_din,
    input  logic              freq_we,
    input  logic [FREQ_W-1:0] freq_din,
    output logic [PAGE_W-1:0] page_q,
    output logic [NSECT-1:0]  prot_q,
    output logic [FREQ_W-1:0] freq_q,
    output logic              cand_prot
);

    logic [SECT_W-1:0] cand_sect;

    // Sector of the page currently on the select bus.
    assign cand_sect = page_din[PAGE_W-1 -: SECT_W];
    assign cand_prot = prot_q[cand_sect];

    // Register updates: page overwrite, protect mask set-only, timing overwrite.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            prot_q <= '0;
            freq_q <= '0;
        end else begin
            if (page_we) page_q <= page_din;
            if (prot_we) prot_q <= prot_q | prot_din;
            if (freq_we) freq_q <= freq_din;
        end
    end

    // R5: protect bits once set are never cleared outside reset.
    p_prot_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q != '0) |=> ((prot_q & $past(prot_q)) == $past(prot_q)));

endmodule

// File: rtl/fsu_timer.sv
// Operation length timer.
// Does: loads the cycle count at operation start and flags the last busy cycle.
// Assumes: load is never raised while run is high; a loaded value of zero is never used.
module fsu_timer #(
    parameter int FREQ_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FREQ_W-1:0] load_val,
    input  logic              run,
    output logic              done
);

    logic [FREQ_W-1:0] cnt_q;

    // Down counter: load on start, decrement each busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = run && (cnt_q == {{(FREQ_W-1){1'b0}}, 1'b1});

    // R7: every busy cycle short of the last consumes exactly one count.
    p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q > {{(FREQ_W-1){1'b0}}, 1'b1}) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fsu_ctrl.sv
// Key sequence and command state machine.
// Does: walks locked -> first key -> second key -> page confirm -> unlocked,
//       launches array operations and relocks on any out-of-order write.
// Assumes: write priority control > select > program within one cycle.
module fsu_ctrl
    import fsu_pkg::*;
#(
    parameter int PAGE_W = 7,
    parameter int OFS_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_din,
    input  logic              sel_we,
    input  logic [PAGE_W-1:0] sel_page,
    input  logic              prog_we,
    input  logic [OFS_W-1:0]  prog_offset,
    input  logic [7:0]        prog_data,
    input  logic              wp_n,
    input  logic [PAGE_W-1:0] page_q,
    input  logic              prot_any,
    input  logic              cand_prot,
    input  logic              freq_nz,
    input  logic              tmr_done,
    output fsu_state_e        state_q,
    output logic              page_we,
    output logic              prot_we,
    output logic              tmr_load,
    output fsu_op_e           op_q,
    output logic [PAGE_W-1:0] op_page_q,
    output logic [OFS_W-1:0]  op_ofs_q,
    output logic [7:0]        op_data_q
);

    fsu_state_e state_d;
    fsu_op_e    op_d;
    logic       start;
    logic       go_ok;
    logic       sel_eff;

    assign go_ok   = wp_n && freq_nz;
    assign sel_eff = sel_we && !ctl_we;

    // Select bus routing: protect mask in protect-select state, page otherwise.
    assign prot_we  = sel_eff && (state_q == ST_PSEL);
    assign page_we  = sel_eff && (state_q != ST_PSEL) && (state_q != ST_BUSY);
    assign tmr_load = start;

    // Next-state decision for every write type in every state.
    always_comb begin
        state_d = state_q;
        op_d    = OP_NONE;
        start   = 1'b0;
        if (state_q == ST_BUSY) begin
            if (tmr_done) state_d = (op_q == OP_PROG) ? ST_OPEN : ST_LOCKED;
        end else if (ctl_we) begin
            case (state_q)
                ST_KEY1: state_d = (ctl_din == KEY_SECOND) ? ST_KEY2 : ST_LOCKED;
                ST_KEY2: state_d = ST_LOCKED;
                ST_OPEN: begin
                    if (ctl_din == CMD_PAGE_ERASE && go_ok) begin
                        state_d = ST_BUSY;
                        op_d    = OP_PERASE;
                        start   = 1'b1;
                    end else if (ctl_din == CMD_MASS_ERASE && go_ok && !prot_any) begin
                        state_d = ST_BUSY;
                        op_d    = OP_MERASE;
                        start   = 1'b1;
                    end else begin
                        state_d = ST_LOCKED;
                    end
                end
                default: begin
                    if (ctl_din == KEY_FIRST)         state_d = ST_KEY1;
                    else if (ctl_din == CMD_PROT_SEL) state_d = ST_PSEL;
                    else                              state_d = ST_LOCKED;
                end
            endcase
        end else if (sel_we) begin
            if (state_q == ST_KEY2 && sel_page == page_q && !cand_prot && wp_n)
                state_d = ST_OPEN;
            else
                state_d = ST_LOCKED;
        end else if (prog_we) begin
            if (state_q == ST_OPEN && go_ok) begin
                state_d = ST_BUSY;
                op_d    = OP_PROG;
                start   = 1'b1;
            end else begin
                state_d = ST_LOCKED;
            end
        end
    end

    // State and operation descriptor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_LOCKED;
            op_q      <= OP_NONE;
            op_page_q <= '0;
            op_ofs_q  <= '0;
            op_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                op_q      <= op_d;
                op_page_q <= page_q;
                op_ofs_q  <= (op_d == OP_PROG) ? prog_offset : '0;
                op_data_q <= (op_d == OP_PROG) ? prog_data : '0;
            end else if (state_q == ST_BUSY && tmr_done) begin
                op_q <= OP_NONE;
            end
        end
    end

    // R2: a wrong second key drops back to locked.
    p_wrong_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEY1 && ctl_we && ctl_din != KEY_SECOND) |=> (state_q == ST_LOCKED));

    // R3: unlocked is reachable only from the second-key state (or from a finished program).
    p_open_via_key2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED || state_q == ST_KEY1 || state_q == ST_PSEL) |=> (state_q != ST_OPEN));

    // R4: confirming into a protected sector never unlocks.
    p_prot_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KEY2 && sel_eff && cand_prot) |=> (state_q == ST_LOCKED));

    // R6: a mass erase never runs while any sector is protected.
    p_merase_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && op_q == OP_MERASE) |-> !prot_any);

    // R7: a zero timing value never starts an operation.
    p_zero_freq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && !freq_nz) |=> (state_q != ST_BUSY));

    // R8: with the strap low the block cannot become unlocked.
    p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && state_q != ST_OPEN && state_q != ST_BUSY) |=> (state_q != ST_OPEN));

    // R9: the operation descriptor is frozen until the last busy cycle.
    p_busy_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !tmr_done) |=>
            (state_q == ST_BUSY && $stable(op_q) && $stable(op_page_q) && $stable(op_data_q)));

endmodule

// File: rtl/flash_unlock_seq.sv
// Top of the flash program/erase unlock sequencer.
// Does: connects the key/command state machine, the register file and the
//       operation timer, and presents status and array strobes.
// Assumes: PAGE_W <= 8 and eight or fewer sectors so both fit in the select byte.
module flash_unlock_seq #(
    parameter int PAGE_W     = 7,
    parameter int SECT_W     = 3,
    parameter int FREQ_W     = 16,
    parameter int PAGE_BYTES = 64,
    localparam int NSECT     = 1 << SECT_W,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_din,
    input  logic              sel_we,
    input  logic [7:0]        sel_din,
    input  logic              freq_we,
    input  logic [FREQ_W-1:0] freq_din,
    input  logic              prog_we,
    input  logic [OFS_W-1:0]  prog_offset,
    input  logic [7:0]        prog_data,
    input  logic              wp_n,
    output logic [5:0]        status,
    output logic [NSECT-1:0]  prot_mask,
    output logic [PAGE_W-1:0] page_sel,
    output logic              arr_busy,
    output logic [1:0]        arr_op,
    output logic [PAGE_W-1:0] arr_page,
    output logic [OFS_W-1:0]  arr_offset,
    output logic [7:0]        arr_data
);
    import fsu_pkg::*;

    fsu_state_e        state;
    fsu_op_e           op;
    logic              page_we, prot_we, tmr_load, tmr_done, cand_prot;
    logic [PAGE_W-1:0] page_q;
    logic [NSECT-1:0]  prot_q;
    logic [FREQ_W-1:0] freq_q;

    fsu_regs #(.PAGE_W(PAGE_W), .SECT_W(SECT_W), .FREQ_W(FREQ_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .page_we   (page_we),
        .page_din  (sel_din[PAGE_W-1:0]),
        .prot_we   (prot_we),
        .prot_din  (sel_din[NSECT-1:0]),
        .freq_we   (freq_we),
        .freq_din  (freq_din),
        .page_q    (page_q),
        .prot_q    (prot_q),
        .freq_q    (freq_q),
        .cand_prot (cand_prot)
    );

    fsu_timer #(.FREQ_W(FREQ_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (freq_q),
        .run      (state == ST_BUSY),
        .done     (tmr_done)
    );

    fsu_ctrl #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (ctl_we),
        .ctl_din     (ctl_din),
        .sel_we      (sel_we),
        .sel_page    (sel_din[PAGE_W-1:0]),
        .prog_we     (prog_we),
        .prog_offset (prog_offset),
        .prog_data   (prog_data),
        .wp_n        (wp_n),
        .page_q      (page_q),
        .prot_any    (prot_q != '0),
        .cand_prot   (cand_prot),
        .freq_nz     (freq_q != '0),
        .tmr_done    (tmr_done),
        .state_q     (state),
        .page_we     (page_we),
        .prot_we     (prot_we),
        .tmr_load    (tmr_load),
        .op_q        (op),
        .op_page_q   (arr_page),
        .op_ofs_q    (arr_offset),
        .op_data_q   (arr_data)
    );

    assign status    = state;
    assign arr_op    = op;
    assign arr_busy  = (state == ST_BUSY);
    assign prot_mask = prot_q;
    assign page_sel  = page_q;

    // R9: the array strobe and a valid operation code always travel together.
    p_busy_has_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_busy |-> (arr_op != 2'b00));

endmodule

// File: tb/sim_flash_unlock_seq.sv
module sim_flash_unlock_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0, sel_we = 1'b0, freq_we = 1'b0, prog_we = 1'b0;
    logic [7:0]  ctl_din = '0, sel_din = '0, prog_data = '0;
    logic [15:0] freq_din = '0;
    logic [5:0]  prog_offset = '0;
    logic        wp_n = 1'b1;
    logic [5:0]  status;
    logic [7:0]  prot_mask;
    logic [6:0]  page_sel, arr_page;
    logic        arr_busy;
    logic [1:0]  arr_op;
    logic [5:0]  arr_offset;
    logic [7:0]  arr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Reference state computed from the requirements.
    logic [5:0]  m_st = 6'd0;
    logic [6:0]  m_page = '0, m_apage = '0;
    logic [7:0]  m_prot = '0, m_adat = '0;
    logic [5:0]  m_aoff = '0;
    logic [15:0] m_freq = '0;
    int          m_rem = 0;
    logic [1:0]  m_op = 2'b00;
    logic        m_wp = 1'b1;

    always #10 clk = ~clk;

    flash_unlock_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_din(ctl_din),
        .sel_we(sel_we), .sel_din(sel_din),
        .freq_we(freq_we), .freq_din(freq_din),
        .prog_we(prog_we), .prog_offset(prog_offset), .prog_data(prog_data),
        .wp_n(wp_n),
        .status(status), .prot_mask(prot_mask), .page_sel(page_sel),
        .arr_busy(arr_busy), .arr_op(arr_op), .arr_page(arr_page),
        .arr_offset(arr_offset), .arr_data(arr_data)
    );

    task automatic m_start(input logic [1:0] op, input logic [5:0] ofs, input logic [7:0] dat);
        m_st    = 6'd5;
        m_rem   = int'(m_freq);
        m_op    = op;
        m_apage = m_page;
        m_aoff  = (op == 2'b01) ? ofs : 6'd0;
        m_adat  = (op == 2'b01) ? dat : 8'd0;
    endtask

    // Kinds: 0 idle, 1 control, 2 select, 3 program, 4 timing, 5 strap.
    task automatic model(input int kind, input logic [7:0] v, input logic [5:0] ofs, input logic [7:0] dat);
        logic ok;
        if (kind == 5) m_wp = v[0];
        ok = m_wp && (m_freq != 0);
        if (m_st == 6'd5) begin
            if (m_rem == 1) begin
                m_st = (m_op == 2'b01) ? 6'd3 : 6'd0;
                m_op = 2'b00;
            end else m_rem--;
        end else if (kind == 1) begin
            case (m_st)
                6'd1: m_st = (v == 8'h8C) ? 6'd2 : 6'd0;
                6'd2: m_st = 6'd0;
                6'd3: begin
                    if (v == 8'h95 && ok) m_start(2'b10, ofs, dat);
                    else if (v == 8'h63 && ok && m_prot == 0) m_start(2'b11, ofs, dat);
                    else m_st = 6'd0;
                end
                default: m_st = (v == 8'h73) ? 6'd1 : (v == 8'h5E) ? 6'd4 : 6'd0;
            endcase
        end else if (kind == 2) begin
            if (m_st == 6'd4) begin
                m_prot = m_prot | v;
                m_st   = 6'd0;
            end else begin
                m_st   = (m_st == 6'd2 && v[6:0] == m_page && !m_prot[v[6:4]] && m_wp) ? 6'd3 : 6'd0;
                m_page = v[6:0];
            end
        end else if (kind == 3) begin
            if (m_st == 6'd3 && ok) m_start(2'b01, ofs, dat);
            else m_st = 6'd0;
        end
        if (kind == 4) m_freq = {8'h00, v};
    endtask

    task automatic compare(input string tag);
        bit bad;
        bad = (status !== m_st) || (arr_busy !== (m_st == 6'd5)) || (arr_op !== m_op) ||
              (prot_mask !== m_prot) || (page_sel !== m_page);
        if (m_st == 6'd5)
            bad = bad || (arr_page !== m_apage) || (arr_offset !== m_aoff) || (arr_data !== m_adat);
        n_checks++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: status=%b op=%b prot=%h page=%h apage=%h aofs=%h adat=%h | expected status=%b op=%b prot=%h page=%h apage=%h aofs=%h adat=%h",
                     tag, status, arr_op, prot_mask, page_sel, arr_page, arr_offset, arr_data,
                     m_st, m_op, m_prot, m_page, m_apage, m_aoff, m_adat);
        end
    endtask

    task automatic step(input int kind, input logic [7:0] v, input logic [5:0] ofs,
                        input logic [7:0] dat, input string tag);
        case (kind)
            1: begin ctl_we = 1'b1; ctl_din = v; end
            2: begin sel_we = 1'b1; sel_din = v; end
            3: begin prog_we = 1'b1; prog_offset = ofs; prog_data = dat; end
            4: begin freq_we = 1'b1; freq_din = {8'h00, v}; end
            5: wp_n = v[0];
            default: ;
        endcase
        model(kind, v, ofs, dat);
        @(posedge clk);
        @(negedge clk);
        ctl_we = 1'b0; sel_we = 1'b0; prog_we = 1'b0; freq_we = 1'b0;
        compare(tag);
    endtask

    task automatic unlock(input logic [7:0] pg, input string tag);
        step(2, pg, 0, 0, tag);
        step(1, 8'h73, 0, 0, tag);
        step(1, 8'h8C, 0, 0, tag);
        step(2, pg, 0, 0, tag);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        // Directed corners.
        step(4, 8'd3, 0, 0, "R7");
        step(2, 8'h25, 0, 0, "R5");
        step(1, 8'h73, 0, 0, "R2");
        step(1, 8'h8C, 0, 0, "R2");
        step(2, 8'h25, 0, 0, "R3");
        step(1, 8'h95, 0, 0, "R6");
        step(0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, "R9");
        step(1, 8'h73, 0, 0, "R2");
        step(1, 8'h11, 0, 0, "R2");
        step(1, 8'h73, 0, 0, "R2");
        step(2, 8'h25, 0, 0, "R2");
        step(1, 8'h73, 0, 0, "R3");
        step(1, 8'h8C, 0, 0, "R3");
        step(2, 8'h26, 0, 0, "R3");
        step(1, 8'h5E, 0, 0, "R5");
        step(2, 8'h04, 0, 0, "R5");
        unlock(8'h25, "R4");
        unlock(8'h10, "R6");
        step(1, 8'h63, 0, 0, "R6");
        unlock(8'h10, "R6");
        step(3, 0, 6'd5, 8'hA5, "R6");
        step(1, 8'h95, 0, 0, "R9");
        step(2, 8'h7F, 0, 0, "R9");
        step(0, 0, 0, 0, "R9");
        step(2, 8'h10, 0, 0, "R6");
        step(4, 8'd0, 0, 0, "R7");
        unlock(8'h10, "R7");
        step(1, 8'h95, 0, 0, "R7");
        step(4, 8'd1, 0, 0, "R7");
        unlock(8'h11, "R7");
        step(3, 0, 6'd63, 8'h3C, "R7");
        step(0, 0, 0, 0, "R7");
        step(5, 8'd0, 0, 0, "R8");
        unlock(8'h11, "R8");
        step(5, 8'd1, 0, 0, "R8");
        unlock(8'h11, "R8");
        step(5, 8'd0, 0, 0, "R8");
        step(1, 8'h95, 0, 0, "R8");
        step(5, 8'd1, 0, 0, "R8");

        // Constrained random walk steered toward the key sequence.
        for (int i = 0; i < 3000; i++) begin
            int r, kind;
            logic [7:0] v;
            r = int'($urandom_range(99));
            v = 8'($urandom);
            kind = 0;
            if (r < 40) begin
                kind = 1;
                case (m_st)
                    6'd1: v = (r < 34) ? 8'h8C : v;
                    6'd3: v = (r < 18) ? 8'h95 : (r < 28) ? 8'h63 : v;
                    default: v = (r < 30) ? 8'h73 : (r < 31) ? 8'h5E : v;
                endcase
            end else if (r < 65) begin
                kind = 2;
                if (m_st == 6'd2 && r < 60) v = {1'b0, m_page};
                if (m_st == 6'd4) v = 8'(1 << $urandom_range(7));
            end else if (r < 80) kind = 3;
            else if (r < 84) begin kind = 4; v = 8'($urandom_range(4)); end
            else if (r < 86) begin kind = 5; v = (r == 85) ? 8'd1 : 8'($urandom_range(1)); end
            step(kind, v, 6'($urandom), 8'($urandom), "RND");
        end
        if (m_wp == 1'b0) step(5, 8'd1, 0, 0, "R8");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule